// File: doc/BRIEF.md
# UART Receive Queue with Trigger and Idle Interrupts

This block sits between a UART deserializer and the CPU bus. Each byte the deserializer finishes is pushed into a 16-entry first-in first-out store, and the CPU takes bytes out with a read strobe. The CPU learns that data is waiting in one of two ways. A data interrupt fires once the occupancy reaches a level chosen by software. An idle interrupt fires when a few leftover bytes sit below that level and the line has gone quiet.

The idle interrupt counts character-time ticks from an external baud divider. If four of those ticks pass with bytes still stored and with no byte arriving and no CPU read, the interrupt asserts. A byte that arrives while the store is full is dropped. Stored bytes are never overwritten, and a sticky overrun flag records the loss until the line-status logic pulses a clear.

Top module: `uart_rx_queue`

## Requirements
- R1: `level` reports the number of stored bytes, from 0 to 16.
  - A `rx_valid` pulse stores a byte when `level` is below 16.
  - A `rd_stb` pulse removes a byte when `level` is nonzero.
  - When both are accepted in the same cycle, `level` is unchanged.
- R2: While `level` is nonzero, `rd_data` shows the oldest stored byte. Bytes leave in the order they arrived.
- R3: `data_irq` is high exactly when `irq_en` is high and `level` is at or above the trigger level.
  - The trigger level is set by `trig_sel`: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
  - `data_irq` drops as soon as `level` falls below the trigger level.
- R4: A `rx_valid` pulse while `level` is 16 discards its byte and sets `overrun`. The stored bytes are kept unchanged. A `rd_stb` in that same cycle still removes a byte.
- R5: `overrun` stays set until a cycle with `ovr_clr` high. If a discard happens in the same cycle as `ovr_clr`, `overrun` stays set.
- R6: `idle_irq` asserts after the fourth `char_tick` cycle counted since the last `rx_valid` or `rd_stb`, provided `level` is nonzero. A tick only counts when it falls in a cycle with neither strobe and with `level` nonzero.
- R7: Any `rx_valid` or `rd_stb` clears `idle_irq` on the next cycle and restarts the count. An empty store also keeps the count at zero.
- R8: With `irq_en` low, both `data_irq` and `idle_irq` are low. Occupancy and the idle count continue to track as usual.
- R9: While `level` is 0, `rd_data` is zero, and a `rd_stb` leaves `level` at 0.
- R10: After synchronous reset, `level`, `rd_data`, `data_irq`, `idle_irq` and `overrun` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe from the deserializer |
| rx_data | input | 8 | Received byte |
| rd_stb | input | 1 | CPU read strobe, removes the oldest byte |
| trig_sel | input | 2 | Trigger level select (1, 4, 8, 14) |
| char_tick | input | 1 | One-cycle pulse per character time |
| irq_en | input | 1 | Receive interrupt enable |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rd_data | output | 8 | Oldest stored byte, zero when empty |
| level | output | 5 | Number of stored bytes |
| data_irq | output | 1 | Trigger-level interrupt |
| idle_irq | output | 1 | Character-timeout interrupt |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The assertions check several rules on every cycle:
- the bound on occupancy and its single-step change;
- that a full store holds its count while a byte is dropped;
- that a drop sets the overrun flag, and that a clear releases it;
- that empty reads are harmless;
- that interrupt masking works;
- that any strobe silences the idle interrupt;
- that the idle interrupt only rises on a tick.

Some behaviour only the bench can show, by comparing against its own queue model:
- the exact byte order through pointer wrap-around;
- that the idle interrupt fires on precisely the fourth qualifying tick and not the third;
- the per-select trigger thresholds.

// File: rtl/rxq_pkg.sv
// Shared constants and types for the UART receive queue.
// Assumes a byte-wide data path and a fixed set of four trigger choices.
package rxq_pkg;

    localparam int unsigned RXQ_DEPTH  = 16;
    localparam int unsigned RXQ_WIDTH  = 8;
    localparam int unsigned IDLE_CHARS = 4;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_sel_e;

    // Map a trigger select code onto a byte threshold
    function automatic int unsigned trig_bytes(trig_sel_e sel);
        case (sel)
            TRIG_ONE:      return 1;
            TRIG_FOUR:     return 4;
            TRIG_EIGHT:    return 8;
            default:       return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
// Circular byte store with occupancy counter.
// Accepts a write only when not full and a read only when not empty.
// Both may happen in one cycle. A write to a full store is reported on
// wr_drop and changes nothing. Read data is zero while empty.
module rxq_store #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_req,
    input  logic [WIDTH-1:0]             wr_data,
    input  logic                         rd_req,
    output logic [WIDTH-1:0]             rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         wr_drop
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             full, empty, wr_ok, rd_ok;

    // Pointer advance with wrap at DEPTH, valid for any depth
    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Decode occupancy and qualify the requests
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        wr_ok   = wr_req && !full;
        rd_ok   = rd_req && !empty;
        wr_drop = wr_req && full;
    end

    // Store accepted bytes; storage needs no reset
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= bump(wr_ptr);
            if (rd_ok) rd_ptr <= bump(rd_ptr);
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // Present the oldest byte, or zero when nothing is stored
    always_comb begin
        rd_data = empty ? '0 : mem[rd_ptr];
    end

endmodule

// File: rtl/rxq_idle_timer.sv
// Character-time idle detector.
// Counts tick pulses while the queue is occupied and untouched, and
// raises `expired` after CHARS ticks. Any touch or an empty queue
// restarts the count. A tick in a touch cycle is not counted.
module rxq_idle_timer #(
    parameter int unsigned CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic touch,
    input  logic occupied,
    input  logic tick,
    output logic expired
);
    localparam int unsigned TW = $clog2(CHARS + 1);

    logic [TW-1:0] ticks;

    // Track elapsed idle character times
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks   <= '0;
            expired <= 1'b0;
        end else if (touch || !occupied) begin
            ticks   <= '0;
            expired <= 1'b0;
        end else if (tick && !expired) begin
            if (ticks == TW'(CHARS - 1)) begin
                expired <= 1'b1;
            end else begin
                ticks <= ticks + TW'(1);
            end
        end
    end

endmodule

// File: rtl/rxq_flags.sv
// Interrupt gating and overrun capture.
// The data interrupt compares occupancy with the selected threshold.
// Both interrupts are masked by the enable. Overrun is sticky, and a
// set in the same cycle as a clear wins over the clear.
module rxq_flags
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  trig_sel_e                  trig_sel,
    input  logic                       irq_en,
    input  logic                       expired,
    input  logic                       drop,
    input  logic                       ovr_clr,
    output logic                       data_irq,
    output logic                       idle_irq,
    output logic                       overrun
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [CW-1:0] threshold;

    // Threshold lookup and interrupt masking
    always_comb begin
        threshold = CW'(trig_bytes(trig_sel));
        data_irq  = irq_en && (count >= threshold);
        idle_irq  = irq_en && expired;
    end

    // Sticky overrun capture
    always_ff @(posedge clk) begin
        if (!rst_n)        overrun <= 1'b0;
        else if (drop)     overrun <= 1'b1;
        else if (ovr_clr)  overrun <= 1'b0;
    end

endmodule

// File: rtl/uart_rx_queue.sv
// UART receive queue top level.
// Joins the byte store, the idle timer and the flag logic. Assumes
// rx_valid, rd_stb and char_tick are single-cycle pulses synchronous
// to clk.
module uart_rx_queue
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    parameter int unsigned WIDTH = RXQ_WIDTH,
    parameter int unsigned CHARS = IDLE_CHARS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_valid,
    input  logic [WIDTH-1:0]           rx_data,
    input  logic                       rd_stb,
    input  logic [1:0]                 trig_sel,
    input  logic                       char_tick,
    input  logic                       irq_en,
    input  logic                       ovr_clr,
    output logic [WIDTH-1:0]           rd_data,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       data_irq,
    output logic                       idle_irq,
    output logic                       overrun
);
    logic drop, expired, touch, occupied;

    // Activity and occupancy seen by the idle timer
    always_comb begin
        touch    = rx_valid || rd_stb;
        occupied = (level != '0);
    end

    rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (rx_valid),
        .wr_data (rx_data),
        .rd_req  (rd_stb),
        .rd_data (rd_data),
        .count   (level),
        .wr_drop (drop)
    );

    rxq_idle_timer #(.CHARS(CHARS)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .touch    (touch),
        .occupied (occupied),
        .tick     (char_tick),
        .expired  (expired)
    );

    rxq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (level),
        .trig_sel (trig_sel_e'(trig_sel)),
        .irq_en   (irq_en),
        .expired  (expired),
        .drop     (drop),
        .ovr_clr  (ovr_clr),
        .data_irq (data_irq),
        .idle_irq (idle_irq),
        .overrun  (overrun)
    );

endmodule

// File: rtl/rxq_checker.sv
// Cycle-by-cycle property checks for uart_rx_queue, attached by bind.
module rxq_checker #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rx_valid,
    input logic                       rd_stb,
    input logic [1:0]                 trig_sel,
    input logic                       char_tick,
    input logic                       irq_en,
    input logic                       ovr_clr,
    input logic [WIDTH-1:0]           rd_data,
    input logic [$clog2(DEPTH+1)-1:0] level,
    input logic                       data_irq,
    input logic                       idle_irq,
    input logic                       overrun
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    // R1
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    // R1
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (level <= $past(level) + CW'(1)) && (level + CW'(1) >= $past(level)));

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rd_stb && level == CW'(DEPTH)) |=> level == CW'(DEPTH));

    // R4
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && level == CW'(DEPTH)) |=> overrun);

    // R5
    overrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !(rx_valid && level == CW'(DEPTH))) |=> !overrun);

    // R9
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> (rd_data == '0));

    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && rd_stb && !rx_valid) |=> level == '0);

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> (!data_irq && !idle_irq));

    // R3
    top_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_irq && trig_sel == 2'b11) |-> level >= CW'(14));

    // R7
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid || rd_stb) |=> !idle_irq);

    // R6
    idle_occupied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_irq |-> level != '0);

    // R6
    idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(idle_irq) && $past(irq_en)) |-> $past(char_tick));

endmodule

bind uart_rx_queue rxq_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rd_stb    (rd_stb),
    .trig_sel  (trig_sel),
    .char_tick (char_tick),
    .irq_en    (irq_en),
    .ovr_clr   (ovr_clr),
    .rd_data   (rd_data),
    .level     (level),
    .data_irq  (data_irq),
    .idle_irq  (idle_irq),
    .overrun   (overrun)
);

// File: tb/uart_rx_queue_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random traffic,
// compared every cycle against a queue model built from the requirements.
module uart_rx_queue_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rd_stb = 1'b0;
    logic [1:0] trig_sel = 2'b00;
    logic       char_tick = 1'b0;
    logic       irq_en = 1'b0;
    logic       ovr_clr = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] level;
    logic       data_irq, idle_irq, overrun;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    logic [7:0] mq[$];
    int         m_ticks = 0;
    bit         m_exp = 0;
    bit         m_ovr = 0;

    always #2.5 clk = ~clk;

    uart_rx_queue uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rd_stb(rd_stb), .trig_sel(trig_sel), .char_tick(char_tick),
        .irq_en(irq_en), .ovr_clr(ovr_clr), .rd_data(rd_data), .level(level),
        .data_irq(data_irq), .idle_irq(idle_irq), .overrun(overrun)
    );

    function automatic int trig_of(logic [1:0] s);
        case (s)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model (called away from the clock edge)
    task automatic compare_all();
        int exp_data = (mq.size() != 0) ? int'(mq[0]) : 0;
        check("R1", "level", int'(level), mq.size());
        if (mq.size() != 0) check("R2", "rd_data", int'(rd_data), exp_data);
        else                check("R9", "rd_data empty", int'(rd_data), 0);
        check(irq_en ? "R3" : "R8", "data_irq", int'(data_irq),
              int'(irq_en && mq.size() >= trig_of(trig_sel)));
        check(irq_en ? "R6" : "R8", "idle_irq", int'(idle_irq), int'(irq_en && m_exp));
        check("R4", "overrun", int'(overrun), int'(m_ovr));
    endtask

    // One clock cycle of stimulus; called at a negative edge
    task automatic step(bit v, logic [7:0] d, bit r, bit t, bit c);
        bit full, occ;
        rx_valid = v; rx_data = d; rd_stb = r; char_tick = t; ovr_clr = c;
        #1;
        compare_all();
        full = (mq.size() == 16);
        occ  = (mq.size() != 0);
        // R6 / R7 idle model
        if (v || r || !occ) begin
            m_ticks = 0; m_exp = 0;
        end else if (t && !m_exp) begin
            if (m_ticks == 3) m_exp = 1;
            else m_ticks++;
        end
        // R4 / R5 overrun model
        if (v && full) m_ovr = 1;
        else if (c)    m_ovr = 0;
        // R1 / R2 queue model
        if (r && occ) void'(mq.pop_front());
        if (v && !full) mq.push_back(d);
        @(negedge clk);
        compare_all();
        rx_valid = 0; rd_stb = 0; char_tick = 0; ovr_clr = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0);
    endtask

    initial begin
        #(150000 * 5);
        n_fail++;
        $display("FAIL R1 watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R10: reset values
        check("R10", "level", int'(level), 0);
        check("R10", "rd_data", int'(rd_data), 0);
        check("R10", "data_irq", int'(data_irq), 0);
        check("R10", "idle_irq", int'(idle_irq), 0);
        check("R10", "overrun", int'(overrun), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: threshold of four
        irq_en = 1; trig_sel = 2'b01;
        for (int i = 0; i < 4; i++) step(1, 8'h10 + 8'(i), 0, 0, 0);

        // R6: three ticks do not expire, the fourth does
        step(0, 0, 0, 1, 0); step(0, 0, 0, 1, 0); step(0, 0, 0, 1, 0);
        check("R6", "idle after 3 ticks", int'(idle_irq), 0);
        idle(2);
        step(0, 0, 0, 1, 0);
        check("R6", "idle after 4 ticks", int'(idle_irq), 1);
        // R7: a read clears it and R3 drops below threshold
        step(0, 0, 1, 0, 0);
        check("R7", "idle after read", int'(idle_irq), 0);
        check("R3", "data_irq below trigger", int'(data_irq), 0);
        // R7: tick in a touch cycle is not counted
        step(1, 8'h55, 0, 1, 0);
        step(0, 0, 0, 1, 0); step(0, 0, 0, 1, 0); step(0, 0, 0, 1, 0);
        check("R7", "idle 3 ticks after touch", int'(idle_irq), 0);
        step(0, 0, 0, 1, 0);

        // R9: drain and read empty
        while (mq.size() != 0) step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0); step(0, 0, 1, 1, 0);
        check("R9", "level after empty read", int'(level), 0);

        // R4: fill, then overflow twice with and without a same-cycle read
        for (int i = 0; i < 16; i++) step(1, 8'hA0 + 8'(i), 0, 0, 0);
        step(1, 8'hEE, 0, 0, 0);
        check("R4", "overrun after drop", int'(overrun), 1);
        step(1, 8'hEF, 1, 0, 0);
        check("R4", "level after drop+read", int'(level), 15);
        // R5: sticky, clear, and set-wins
        idle(3);
        step(1, 8'h01, 0, 0, 0);
        step(1, 8'h02, 0, 0, 1);
        check("R5", "set wins over clear", int'(overrun), 1);
        step(0, 0, 0, 0, 1);
        check("R5", "overrun cleared", int'(overrun), 0);

        // R8: masking with a full store and expired idle state
        irq_en = 0; trig_sel = 2'b11;
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0);
        irq_en = 1;
        step(0, 0, 0, 0, 0);
        check("R8", "idle state kept while masked", int'(idle_irq), 1);

        // R3: sweep every select while draining
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0);
            for (int i = 0; i < 3; i++) step(1, 8'(s * 16 + i), 0, 0, 0);
        end

        // Random traffic in phases of differing write/read pressure
        for (int ph = 0; ph < 40; ph++) begin
            int wp = $urandom_range(10, 90);
            int rp = $urandom_range(5, 90);
            int tp = $urandom_range(5, 60);
            trig_sel = 2'($urandom_range(0, 3));
            irq_en = ($urandom_range(0, 9) != 0);
            for (int i = 0; i < 100; i++)
                step($urandom_range(0, 99) < wp, 8'($urandom),
                     $urandom_range(0, 99) < rp, $urandom_range(0, 99) < tp,
                     $urandom_range(0, 29) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule